// File: doc/BRIEF.md
# Summed-Power Sign-Change Interrupt Unit

This block watches a set of independent energy-to-pulse channels, three by default. For each channel it receives three inputs: a one-cycle strobe that marks the moment the first accumulation stage reaches its threshold, the sign of that channel's summed phase power, and the level of the channel's output pulse. The block samples the sign only on the threshold strobe. It compares the sample with a stored last sign, which resets to positive. When the two differ, a change is held pending.

A pending change is not reported at once. It waits for the next high-to-low transition of that channel's output pulse. At that clock edge the channel's change flag is set, and the channel's bit in the sign register is written with the new sign (0 for positive, 1 for negative). As a result, every report lines up with a pulse.

Flags whose enable bit is set pull the active-low interrupt output low. Software first reads the flag register and then the sign register to find out which channel fired. It clears a flag by writing 1 to that flag's bit position.

Top module: `psum_sign_irq`

## Requirements
- R1: After reset, the flag, enable and sign registers all read 0 and `irq_n` is 1.
- R2: The sign input is sampled only in cycles where `thr_evt` is high for that channel. Sign changes without a strobe never raise a flag, even after a pulse falling edge.
- R3: A change means a strobed sign that differs from the channel's stored last sign. That stored sign is positive after reset and is updated on every strobe. A strobe with the same sign raises nothing.
- R4: A flag is set at the clock edge that samples `pulse_in` low while the previous cycle's sample was high, and only if a change is pending. It is never set earlier. A pending change is consumed by that edge.
- R5: A channel's sign-register bit is written in the same cycle as its flag is set, and at no other time. The value is 0 for a positive sum and 1 for a negative sum.
- R6: `irq_n` is 0 exactly when some flag bit and the matching enable bit are both 1. A flag whose enable bit is 0 has no effect on `irq_n`.
- R7: A write to address 0 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. `irq_n` returns to 1 once no enabled flag remains. A flag is cleared by no other means.
- R8: If a flag is set and cleared by a write in the same cycle, the set wins.
- R9: Several changes detected before the pulse edge merge into one flag. The sign bit shows the most recently strobed sign, and later pulse edges raise nothing more.
- R10: The register map, with bit i belonging to channel i, is: address 0 for flags, address 1 for enables (read/write), address 2 for signs (read-only), and address 3 reads 0. `rd_data` follows `rd_addr` without a clock delay.
- R11: Channels are independent. A pulse edge on one channel never reports another channel's pending change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_evt | input | N_CH | Per-channel first-stage threshold strobe |
| sum_neg | input | N_CH | Per-channel sign of summed power (1 = negative) |
| pulse_in | input | N_CH | Per-channel output pulse level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | N_CH | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | N_CH | Register read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The properties assume that `thr_evt`, `sum_neg`, `pulse_in` and the write port are synchronous to `clk` and are held at 0 while reset is asserted. They also treat `pulse_in` as a level whose only meaningful event is a sampled high-to-low step. The stimulus changes every input half a cycle away from the active edge. It keeps each threshold strobe one cycle wide, and it raises and drops each pulse on its own cycle boundaries. Because of this, a falling edge is always preceded by a sampled high. The bench mirrors each channel's stored last sign in its own bookkeeping, so every expected flag and sign value follows from the order of the strobes it applied.

// File: rtl/psum_sign_pkg.sv
package psum_sign_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_FLAG = 2'd0,
      REG_ENAB = 2'd1,
      REG_SIGN = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/psum_chan_track.sv
module psum_chan_track (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_evt,
   input  logic sum_neg,
   input  logic pulse_in,
   output logic fire,
   output logic fire_sign,
   output logic pend,
   output logic pulse_q
);
   logic last_sign_q;
   logic pend_sign_q;
   logic det;
   logic fall;

   // a change is a strobed sign differing from the stored one
   assign det  = thr_evt && (sum_neg != last_sign_q);
   assign fall = pulse_q && !pulse_in;
   assign fire = fall && pend;
   assign fire_sign = pend_sign_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_sign_q <= 1'b0;
         pend_sign_q <= 1'b0;
         pend        <= 1'b0;
         pulse_q     <= 1'b0;
      end else begin
         pulse_q <= pulse_in;
         if (thr_evt) last_sign_q <= sum_neg;
         if (det)     pend_sign_q <= sum_neg;
         // new detection merges with or re-arms the pending slot
         pend <= det | (pend & ~fall);
      end
   end
endmodule

// File: rtl/psum_flag_regs.sv
module psum_flag_regs
   import psum_sign_pkg::*;
#(
   parameter int unsigned N_CH = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_CH-1:0]       fire,
   input  logic [N_CH-1:0]       fire_sign,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [N_CH-1:0]       wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [N_CH-1:0]       rd_data,
   output logic [N_CH-1:0]       flag_q,
   output logic [N_CH-1:0]       enab_q,
   output logic [N_CH-1:0]       sign_q,
   output logic                  irq_n
);
   logic [N_CH-1:0] clr;
   logic            enab_we;

   assign clr     = (wr_en && wr_addr == REG_FLAG) ? wr_data : '0;
   assign enab_we = wr_en && (wr_addr == REG_ENAB);

   for (genvar i = 0; i < N_CH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
            sign_q[i] <= 1'b0;
         end else begin
            // set has priority over write-one-to-clear
            if (fire[i])     flag_q[i] <= 1'b1;
            else if (clr[i]) flag_q[i] <= 1'b0;
            if (fire[i])     sign_q[i] <= fire_sign[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       enab_q <= '0;
      else if (enab_we) enab_q <= wr_data;
   end

   always_comb begin
      unique case (rd_addr)
         REG_FLAG: rd_data = flag_q;
         REG_ENAB: rd_data = enab_q;
         REG_SIGN: rd_data = sign_q;
         default:  rd_data = '0;
      endcase
   end

   assign irq_n = ~|(flag_q & enab_q);
endmodule

// File: rtl/psum_sign_irq.sv
module psum_sign_irq
   import psum_sign_pkg::*;
#(
   parameter int unsigned N_CH = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_CH-1:0]       thr_evt,
   input  logic [N_CH-1:0]       sum_neg,
   input  logic [N_CH-1:0]       pulse_in,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [N_CH-1:0]       wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [N_CH-1:0]       rd_data,
   output logic                  irq_n
);
   if (N_CH < 1 || N_CH > 32) begin : g_bad_nch
      $error("psum_sign_irq: N_CH must be within 1..32");
   end

   logic [N_CH-1:0] fire;
   logic [N_CH-1:0] fire_sign;
   logic [N_CH-1:0] pend_q;
   logic [N_CH-1:0] pulse_q;
   logic [N_CH-1:0] flag_q;
   logic [N_CH-1:0] enab_q;
   logic [N_CH-1:0] sign_q;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      psum_chan_track u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .thr_evt   (thr_evt[c]),
         .sum_neg   (sum_neg[c]),
         .pulse_in  (pulse_in[c]),
         .fire      (fire[c]),
         .fire_sign (fire_sign[c]),
         .pend      (pend_q[c]),
         .pulse_q   (pulse_q[c])
      );
   end

   psum_flag_regs #(.N_CH(N_CH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .fire_sign (fire_sign),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .flag_q    (flag_q),
      .enab_q    (enab_q),
      .sign_q    (sign_q),
      .irq_n     (irq_n)
   );
endmodule

// File: rtl/psum_sign_irq_chk.sv
module psum_sign_irq_chk #(
   parameter int unsigned N_CH = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] thr_evt,
   input logic [N_CH-1:0] pulse_in,
   input logic            wr_en,
   input logic [1:0]      wr_addr,
   input logic [N_CH-1:0] wr_data,
   input logic [N_CH-1:0] pend_q,
   input logic [N_CH-1:0] pulse_q,
   input logic [N_CH-1:0] flag_q,
   input logic [N_CH-1:0] enab_q,
   input logic [N_CH-1:0] sign_q,
   input logic            irq_n
);
   AST_IRQ_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (|(flag_q & enab_q))); // R6

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      AST_PEND_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q[i]) |-> $past(thr_evt[i])); // R2

      AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_q[i]) |-> ($past(pend_q[i]) && $past(pulse_q[i]) && !$past(pulse_in[i]))); // R4

      AST_SIGN_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(sign_q[i]) |-> flag_q[i]); // R5

      AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag_q[i]) |-> $past(wr_en && wr_addr == 2'd0 && wr_data[i])); // R7

      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         $past(pend_q[i] && pulse_q[i] && !pulse_in[i]) |-> flag_q[i]); // R8
   end
endmodule

bind psum_sign_irq psum_sign_irq_chk #(.N_CH(N_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .thr_evt  (thr_evt),
   .pulse_in (pulse_in),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .pend_q   (pend_q),
   .pulse_q  (pulse_q),
   .flag_q   (flag_q),
   .enab_q   (enab_q),
   .sign_q   (sign_q),
   .irq_n    (irq_n)
);

// File: tb/tb_psum_sign_irq.sv
module tb_psum_sign_irq;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] thr_evt = '0;
   logic [N-1:0] sum_neg = '0;
   logic [N-1:0] pulse_in = '0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [N-1:0] wr_data = '0;
   logic [1:0]   rd_addr = '0;
   logic [N-1:0] rd_data;
   logic         irq_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   psum_sign_irq #(.N_CH(N)) dut (
      .clk(clk), .rst_n(rst_n), .thr_evt(thr_evt), .sum_neg(sum_neg),
      .pulse_in(pulse_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd_chk(string req, logic [1:0] a, logic [N-1:0] exp);
      rd_addr = a;
      #1;
      chk(req, 32'(rd_data), 32'(exp));
   endtask

   task automatic wr(logic [1:0] a, logic [N-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic strobe(int ch, logic neg);
      thr_evt[ch] = 1'b1; sum_neg[ch] = neg;
      step();
      thr_evt[ch] = 1'b0;
   endtask

   task automatic pulse(int ch);
      pulse_in[ch] = 1'b1;
      step();
      pulse_in[ch] = 1'b0;
      step();
   endtask

   task automatic t_reset();
      rd_chk("R1 flags", 2'd0, 3'b000);
      rd_chk("R1 enables", 2'd1, 3'b000);
      rd_chk("R1 signs", 2'd2, 3'b000);
      chk("R1 irq_n", 32'(irq_n), 32'd1);
      rd_chk("R10 unused address", 2'd3, 3'b000);
   endtask

   task automatic t_no_strobe();
      sum_neg = 3'b111;
      step();
      pulse(0); pulse(1); pulse(2);
      sum_neg = '0;
      rd_chk("R2 no flag without strobe", 2'd0, 3'b000);
   endtask

   task automatic t_same_sign();
      strobe(0, 1'b0); strobe(1, 1'b0);
      pulse(0); pulse(1);
      rd_chk("R3 same sign raises nothing", 2'd0, 3'b000);
   endtask

   task automatic t_basic();
      wr(2'd1, 3'b111);
      rd_chk("R10 enable readback", 2'd1, 3'b111);
      strobe(0, 1'b1);
      pulse_in[0] = 1'b1;
      step();
      rd_chk("R4 not set before falling edge", 2'd0, 3'b000);
      chk("R6 irq_n high before edge", 32'(irq_n), 32'd1);
      pulse_in[0] = 1'b0;
      step();
      rd_chk("R4 flag on falling edge", 2'd0, 3'b001);
      rd_chk("R5 sign negative with flag", 2'd2, 3'b001);
      chk("R6 irq_n low", 32'(irq_n), 32'd0);
   endtask

   task automatic t_clear();
      wr(2'd0, 3'b110);
      rd_chk("R7 write zero keeps flag", 2'd0, 3'b001);
      wr(2'd0, 3'b001);
      rd_chk("R7 write one clears", 2'd0, 3'b000);
      chk("R7 irq_n back high", 32'(irq_n), 32'd1);
      rd_chk("R5 sign kept after clear", 2'd2, 3'b001);
   endtask

   task automatic t_mask();
      wr(2'd1, 3'b000);
      strobe(1, 1'b1);
      pulse(1);
      rd_chk("R6 masked flag still set", 2'd0, 3'b010);
      chk("R6 masked flag no irq", 32'(irq_n), 32'd1);
      wr(2'd1, 3'b010);
      chk("R6 enabling asserts irq", 32'(irq_n), 32'd0);
      wr(2'd0, 3'b010);
      chk("R7 irq released", 32'(irq_n), 32'd1);
   endtask

   task automatic t_priority();
      wr(2'd1, 3'b111);
      strobe(2, 1'b1);
      pulse_in[2] = 1'b1;
      step();
      pulse_in[2] = 1'b0;
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 3'b100;
      step();
      wr_en = 1'b0; wr_data = '0;
      rd_chk("R8 set beats clear", 2'd0, 3'b100);
      rd_chk("R5 sign after priority", 2'd2, 3'b111);
      wr(2'd0, 3'b100);
   endtask

   task automatic t_merge();
      strobe(0, 1'b0);
      strobe(0, 1'b1);
      strobe(0, 1'b0);
      pulse(0);
      rd_chk("R9 merged single flag", 2'd0, 3'b001);
      rd_chk("R9 latest sign positive", 2'd2, 3'b110);
      wr(2'd0, 3'b001);
      pulse(0);
      rd_chk("R9 pending consumed", 2'd0, 3'b000);
   endtask

   task automatic t_indep();
      strobe(1, 1'b0);
      pulse(0); pulse(2);
      rd_chk("R11 other pulses ignored", 2'd0, 3'b000);
      pulse(1);
      rd_chk("R11 own pulse reports", 2'd0, 3'b010);
      rd_chk("R11 sign positive again", 2'd2, 3'b100);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_no_strobe();
      t_same_sign();
      t_basic();
      t_clear();
      t_mask();
      t_priority();
      t_merge();
      t_indep();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule